// File: doc/BRIEF.md
# Two-Wire Display RAM Slave

This block is the two-wire serial (I2C) slave front end of a character display controller. An oversampling system clock watches the SCL and SDA lines. The block detects start and stop conditions, shifts bytes in and out, and pulls SDA low to acknowledge. After a matching write address, a control byte routes the payload bytes that follow. They either go to an instruction decoder (set address, return home) or into a 128-byte display data RAM at the position held by an address counter.

Reads use a one-byte pipeline. A data register holds the next byte to send. During the acknowledge of a read address, that register is copied into the transmit shifter. Each acknowledge from the master then fetches the byte at the address counter into both the data register and the shifter, and advances the counter. Return home clears the counter but leaves the data register as it was, so the first byte read after it is stale. A missing master acknowledge changes nothing.

Top module: `dispram_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal the six-bit device prefix (parameter DEV_ADDR_HI, default 0b011101) followed by the level of `addr_pin_i`. Bit 0 of the address byte selects a read when it is 1. Any other address gets no acknowledge, and the slave stays silent until the next start.
- R2: After a write address, a control byte is decoded as follows: bit 7 is the continuation flag and bit 6 selects the target (0 = instruction, 1 = RAM data). When bit 7 is 0, every later byte in the transfer is payload under that target. When bit 7 is 1, exactly one payload byte follows, and then another control byte.
- R3: A payload byte to the RAM target is stored at the address counter, and the counter then advances by one.
- R4: An instruction byte with bit 7 = 1 is set-address. Its bits 6..0 name a RAM location. That location is copied into the data register, and the counter becomes that location plus one.
- R5: An instruction byte matching 0000001x is return-home. It clears the counter, leaves RAM and the data register unchanged, and the next read therefore first returns the old data register.
- R6: Any other instruction byte is acknowledged and has no effect on the counter, the data register or RAM.
- R7: During the acknowledge of a read address, the data register is copied into the transmit shifter. Read bytes are driven onto SDA most significant bit first, with each bit changed only while SCL is low.
- R8: When the master acknowledges a read byte, the RAM byte at the counter is loaded into the shifter and the data register, and the counter advances.
- R9: When the master does not acknowledge a read byte, the counter, the data register and the shifter stay unchanged, and SDA is released.
- R10: The slave never pulls SDA low while the master owns the line: during address, control and payload bits, and during the master acknowledge slot of a read.
- R11: A stop or start condition abandons any byte in progress without side effects, and SDA is released. After reset, SDA is released.
- R12: The counter is seven bits wide and wraps from 127 to 0 on both writes and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_pin_i | input | 1 | Static level used as the lowest bit of the slave address |
| scl_i | input | 1 | Serial clock line (asynchronous) |
| sda_i | input | 1 | Serial data line as seen on the bus (asynchronous) |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain); 0 releases it |

## Verification
The bench builds the block with its default parameters: a 7-bit counter over 128 bytes, an 8-bit data width, a two-flop synchronizer and the device prefix 0b011101. With these, both the counter wrap at 127 and the two values of the pin-selected address bit can be reached within a few transfers. An SCL half period of 20 system clocks leaves room for the synchronizer latency, so the bench can check that the slave releases SDA in the master's slots on every clock.

// File: rtl/dispram_pkg.sv
// Shared types for the two-wire display RAM slave.
// Assumes 8-bit bytes on the bus; the control byte bit positions are fixed.
package dispram_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,       // waiting for a start condition
        ST_RX,         // shifting a byte in from the master
        ST_ACK_SETUP,  // byte complete, waiting for SCL low to drive ack
        ST_ACK_DRIVE,  // holding SDA low through the ack clock
        ST_TX,         // shifting a byte out to the master
        ST_MACK        // master acknowledge slot after a read byte
    } link_state_t;

    typedef enum logic [1:0] {
        ROLE_ADDR,
        ROLE_CTRL,
        ROLE_DATA
    } byte_role_t;

    localparam int CTRL_CONT_BIT = 7;
    localparam int CTRL_SEL_BIT  = 6;
endpackage

// File: rtl/dispram_line_sync.sv
// Line synchronizer and event detector.
// Brings SCL and SDA into the clk domain through STAGES flops and flags
// SCL edges plus start (SDA falls, SCL high) and stop (SDA rises, SCL high).
// Assumes STAGES >= 2 and SCL/SDA slow compared to clk.
module dispram_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    // Resynchronise both lines and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    // Decode edges and bus conditions from the synchronized levels.
    always_comb begin
        scl_lvl   = scl_pipe[STAGES-1];
        sda_lvl   = sda_pipe[STAGES-1];
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end
endmodule

// File: rtl/dispram_store.sv
// Display data RAM: one write port, one combinational read port.
// Cleared by reset. Assumes at most one write per cycle.
module dispram_store #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Clear on reset, otherwise store the addressed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dispram_cursor.sv
// Address counter and read data register.
// Priority: clear, then load, then increment. The counter wraps naturally.
// The data register only changes on an explicit load.
module dispram_cursor #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ac_clr,
    input  logic          ac_load,
    input  logic [AW-1:0] ac_load_val,
    input  logic          ac_inc,
    input  logic          dreg_ld,
    input  logic [DW-1:0] dreg_val,
    output logic [AW-1:0] ac,
    output logic [DW-1:0] dreg
);
    localparam logic [AW-1:0] AC_STEP = AW'(1);

    // Update the address counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac <= '0;
        end else if (ac_clr) begin
            ac <= '0;
        end else if (ac_load) begin
            ac <= ac_load_val;
        end else if (ac_inc) begin
            ac <= ac + AC_STEP;
        end
    end

    // Capture a fetched byte into the data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dreg <= '0;
        end else if (dreg_ld) begin
            dreg <= dreg_val;
        end
    end

    assert_inc_wraps_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ac_inc && !ac_clr && !ac_load) |=> (ac == $past(ac) + AC_STEP));
endmodule

// File: rtl/dispram_proto.sv
// Protocol engine: byte shifting, acknowledge, control byte and instruction
// decode, read pipeline control. Emits single-cycle commands to the RAM
// and cursor. Assumes AW <= DW-1 and that addr_pin is static.
module dispram_proto
    import dispram_pkg::*;
#(
    parameter int          AW          = 7,
    parameter int          DW          = 8,
    parameter logic [5:0]  DEV_ADDR_HI = 6'b011101
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_pin,
    input  logic          sda_lvl,
    input  logic          scl_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [AW-1:0] ac,
    input  logic [DW-1:0] dreg,
    input  logic [DW-1:0] rd_data,
    output logic          sda_oe,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] mem_raddr,
    output logic          ac_clr,
    output logic          ac_load,
    output logic [AW-1:0] ac_load_val,
    output logic          ac_inc,
    output logic          dreg_ld
);
    localparam int              CW       = $clog2(DW);
    localparam logic [CW-1:0]   LAST_BIT = CW'(DW - 1);
    localparam logic [AW-1:0]   AW_ONE   = AW'(1);

    link_state_t   state;
    byte_role_t    role;
    logic [CW-1:0] bit_cnt;
    logic [DW-1:0] shreg;
    logic [DW-1:0] txsh;
    logic          do_ack;
    logic          rs_q;
    logic          co_q;
    logic          got_ack;

    logic [DW-1:0] byte_in;
    logic          addr_hit;
    logic          act_data;
    logic          mack_take;
    logic          is_set;
    logic          is_home;

    // Decode the incoming byte and the commands for this cycle.
    always_comb begin
        byte_in   = {shreg[DW-2:0], sda_lvl};
        addr_hit  = (byte_in[DW-1:1] == {DEV_ADDR_HI, addr_pin});
        act_data  = (state == ST_ACK_DRIVE) && scl_fall && (role == ROLE_DATA)
                    && !start_det && !stop_det;
        mack_take = (state == ST_MACK) && scl_rise && !sda_lvl
                    && !start_det && !stop_det;
        is_set    = !rs_q && shreg[DW-1];
        is_home   = !rs_q && (shreg[DW-1:1] == 7'b0000001);
        mem_we      = act_data && rs_q;
        mem_wdata   = shreg;
        ac_load     = act_data && is_set;
        ac_load_val = shreg[AW-1:0] + AW_ONE;
        ac_clr      = act_data && is_home;
        ac_inc      = mem_we || mack_take;
        dreg_ld     = ac_load || mack_take;
        mem_raddr   = ac_load ? shreg[AW-1:0] : ac;
    end

    // Bus sequencing: receive, acknowledge, transmit, master acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            role    <= ROLE_ADDR;
            bit_cnt <= '0;
            shreg   <= '0;
            txsh    <= '0;
            sda_oe  <= 1'b0;
            do_ack  <= 1'b0;
            rs_q    <= 1'b0;
            co_q    <= 1'b0;
            got_ack <= 1'b0;
        end else if (start_det) begin
            state   <= ST_RX;
            role    <= ROLE_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        shreg   <= byte_in;
                        bit_cnt <= bit_cnt + CW'(1);
                        if (bit_cnt == LAST_BIT) begin
                            state  <= ST_ACK_SETUP;
                            do_ack <= (role != ROLE_ADDR) || addr_hit;
                        end
                    end
                end
                ST_ACK_SETUP: begin
                    if (scl_fall) begin
                        if (do_ack) begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK_DRIVE;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ACK_DRIVE: begin
                    if (scl_fall) begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                        state   <= ST_RX;
                        case (role)
                            ROLE_ADDR: begin
                                if (shreg[0]) begin
                                    txsh   <= dreg;
                                    sda_oe <= ~dreg[DW-1];
                                    state  <= ST_TX;
                                end else begin
                                    role <= ROLE_CTRL;
                                end
                            end
                            ROLE_CTRL: begin
                                co_q <= shreg[CTRL_CONT_BIT];
                                rs_q <= shreg[CTRL_SEL_BIT];
                                role <= ROLE_DATA;
                            end
                            default: begin
                                role <= co_q ? ROLE_CTRL : ROLE_DATA;
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt == LAST_BIT) begin
                            sda_oe <= 1'b0;
                            state  <= ST_MACK;
                        end else begin
                            sda_oe  <= ~txsh[DW-2];
                            txsh    <= txsh << 1;
                            bit_cnt <= bit_cnt + CW'(1);
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        got_ack <= !sda_lvl;
                        if (!sda_lvl) begin
                            txsh <= rd_data;
                        end
                    end else if (scl_fall) begin
                        if (got_ack) begin
                            sda_oe  <= ~txsh[DW-1];
                            bit_cnt <= '0;
                            state   <= ST_TX;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assert_no_ack_on_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK_SETUP && !do_ack) |-> !sda_oe);
    assert_sda_moves_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);
    assert_nack_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MACK && scl_rise && sda_lvl && !start_det && !stop_det)
        |=> ($stable(ac) && $stable(dreg) && $stable(txsh)));
    assert_release_in_mack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MACK) |-> !sda_oe);
    assert_stop_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && state == ST_IDLE));
endmodule

// File: rtl/dispram_i2c_slave.sv
// Top: two-wire display RAM slave. Wires the line synchronizer, protocol
// engine, address counter / data register and the RAM together.
// Assumes SCL is not stretched and the SCL half period spans several clk cycles.
module dispram_i2c_slave #(
    parameter int         AW          = 7,
    parameter int         DW          = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] DEV_ADDR_HI = 6'b011101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_pin_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);
    localparam logic [AW-1:0] AC_STEP = AW'(1);

    logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [AW-1:0] ac;
    logic [DW-1:0] dreg;
    logic [DW-1:0] rd_data;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [AW-1:0] mem_raddr;
    logic          ac_clr, ac_load, ac_inc, dreg_ld;
    logic [AW-1:0] ac_load_val;

    dispram_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    dispram_proto #(.AW(AW), .DW(DW), .DEV_ADDR_HI(DEV_ADDR_HI)) u_proto (
        .clk(clk), .rst_n(rst_n), .addr_pin(addr_pin_i), .sda_lvl(sda_lvl),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .ac(ac), .dreg(dreg),
        .rd_data(rd_data), .sda_oe(sda_oe_o), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_raddr(mem_raddr), .ac_clr(ac_clr),
        .ac_load(ac_load), .ac_load_val(ac_load_val), .ac_inc(ac_inc),
        .dreg_ld(dreg_ld)
    );

    dispram_cursor #(.AW(AW), .DW(DW)) u_cursor (
        .clk(clk), .rst_n(rst_n), .ac_clr(ac_clr), .ac_load(ac_load),
        .ac_load_val(ac_load_val), .ac_inc(ac_inc), .dreg_ld(dreg_ld),
        .dreg_val(rd_data), .ac(ac), .dreg(dreg)
    );

    dispram_store #(.AW(AW), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(ac), .wdata(mem_wdata),
        .raddr(mem_raddr), .rdata(rd_data)
    );

    assert_write_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (ac == $past(ac) + AC_STEP));
    assert_set_addr_prefetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ac_load |=> (ac == $past(ac_load_val) && dreg == $past(rd_data)));
    assert_home_keeps_dreg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ac_clr |=> (ac == '0 && $stable(dreg)));
endmodule

// File: tb/dispram_i2c_slave_bench.sv
module dispram_i2c_slave_bench;
    localparam int HALF = 20;
    localparam logic [7:0] WR_ADDR = 8'h74;
    localparam logic [7:0] RD_ADDR = 8'h75;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_pin = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe_o;
    wire  sda_bus = m_sda & ~sda_oe_o;

    int vectors = 0;
    int miscompares = 0;
    bit watch = 1'b0;
    bit done = 1'b0;

    int mdl_mem[128];
    int mdl_ac = 0;
    int mdl_dreg = 0;
    int mdl_sh = 0;
    bit mdl_rs = 1'b0;

    always #2.5 clk = ~clk;

    dispram_i2c_slave u_dispram_i2c_slave (
        .clk(clk), .rst_n(rst_n), .addr_pin_i(addr_pin), .scl_i(scl),
        .sda_i(sda_bus), .sda_oe_o(sda_oe_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-clock reference: slave must leave SDA alone in master-owned slots (R10).
    always @(negedge clk) begin
        if (watch && rst_n) check("R10 slave released", int'(sda_oe_o), 0);
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(HALF);
        scl = 1'b1;   tick(HALF);
        m_sda = 1'b0; tick(HALF);
        scl = 1'b0;   tick(4);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(HALF);
        scl = 1'b1;   tick(HALF);
        m_sda = 1'b1; tick(HALF);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i];
            tick(HALF);
            watch = 1'b1;
            scl = 1'b1;
            tick(HALF);
            watch = 1'b0;
            scl = 1'b0;
        end
        m_sda = 1'b1;
        tick(HALF);
        scl = 1'b1;
        tick(HALF / 2);
        acked = !sda_bus;
        tick(HALF / 2);
        scl = 1'b0;
    endtask

    task automatic get_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(HALF);
            scl = 1'b1;
            tick(HALF / 2);
            b[i] = sda_bus;
            tick(HALF / 2);
            scl = 1'b0;
        end
        m_sda = give_ack ? 1'b0 : 1'b1;
        tick(8);
        watch = 1'b1;
        tick(HALF - 8);
        scl = 1'b1;
        tick(HALF);
        watch = 1'b0;
        scl = 1'b0;
        m_sda = 1'b1;
    endtask

    task automatic partial_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; tick(HALF);
            scl = 1'b1;   tick(HALF);
            scl = 1'b0;
        end
    endtask

    task automatic send_addr(input logic [7:0] b, input bit exp, input string tag);
        bit a;
        put_byte(b, a);
        check(tag, int'(a), int'(exp));
    endtask

    task automatic send_ctrl(input logic [7:0] b);
        bit a;
        put_byte(b, a);
        check("R2 control ack", int'(a), 1);
        mdl_rs = b[6];
    endtask

    // Reference behaviour of one payload byte under the selected target.
    task automatic send_payload(input logic [7:0] b, input string tag);
        bit a;
        put_byte(b, a);
        check(tag, int'(a), 1);
        if (mdl_rs) begin
            mdl_mem[mdl_ac] = int'(b);
            mdl_ac = (mdl_ac + 1) % 128;
        end else if (b[7]) begin
            mdl_dreg = mdl_mem[int'(b[6:0])];
            mdl_ac = (int'(b[6:0]) + 1) % 128;
        end else if (b[7:1] == 7'b0000001) begin
            mdl_ac = 0;
        end
    endtask

    task automatic open_read();
        bus_start();
        send_addr(RD_ADDR, 1'b1, "R7 read address ack");
        mdl_sh = mdl_dreg;
    endtask

    task automatic fetch(input bit ack, input string tag);
        logic [7:0] b;
        get_byte(ack, b);
        check(tag, int'(b), mdl_sh);
        if (ack) begin
            mdl_sh = mdl_mem[mdl_ac];
            mdl_dreg = mdl_sh;
            mdl_ac = (mdl_ac + 1) % 128;
        end
    endtask

    task automatic set_addr(input int a);
        bus_start();
        send_addr(WR_ADDR, 1'b1, "R1 write address ack");
        send_ctrl(8'h00);
        send_payload(8'h80 | 8'(a), "R4 set address ack");
        bus_stop();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int keep_ac;
        for (int i = 0; i < 128; i++) mdl_mem[i] = 0;
        tick(6);
        rst_n = 1'b1;
        tick(6);
        check("R11 released after reset", int'(sda_oe_o), 0);

        // R3: stream of RAM writes from address 0
        bus_start();
        send_addr(WR_ADDR, 1'b1, "R1 write address ack");
        send_ctrl(8'h40);
        send_payload(8'h48, "R3 write");
        send_payload(8'h49, "R3 write");
        send_payload(8'h53, "R3 write");
        send_payload(8'h21, "R3 write");
        send_payload(8'h3F, "R3 write");
        bus_stop();

        // R4 then R7/R8/R9: prefetched read from location 2
        set_addr(2);
        open_read();
        fetch(1'b1, "R7 first byte from data register");
        fetch(1'b1, "R8 acked fetch");
        fetch(1'b0, "R9 last byte");
        bus_stop();
        check("R9 released after nack", int'(sda_oe_o), 0);

        // R9: nothing advanced, data register resent
        open_read();
        fetch(1'b1, "R9 data register unchanged");
        fetch(1'b0, "R8 fetch after ack");
        bus_stop();

        // R5, R6, R2: return home, ignored codes, continuation flag
        bus_start();
        send_addr(WR_ADDR, 1'b1, "R1 write address ack");
        send_ctrl(8'h80);
        send_payload(8'h03, "R5 return home ack");
        send_ctrl(8'h00);
        send_payload(8'h55, "R6 ignored ack");
        send_payload(8'h04, "R6 ignored ack");
        bus_stop();
        open_read();
        fetch(1'b1, "R5 stale data register");
        fetch(1'b0, "R5 location 0 after home");
        bus_stop();

        // R2: one RAM byte under continuation, then instruction target
        bus_start();
        send_addr(WR_ADDR, 1'b1, "R1 write address ack");
        send_ctrl(8'hC0);
        send_payload(8'hA5, "R2 single data byte");
        send_ctrl(8'h00);
        send_payload(8'h81, "R2 instruction after control");
        bus_stop();
        open_read();
        fetch(1'b0, "R2 continuation write landed");
        bus_stop();

        // R12: wrap on write and on read
        bus_start();
        send_addr(WR_ADDR, 1'b1, "R1 write address ack");
        send_ctrl(8'h80);
        send_payload(8'hFE, "R4 set address ack");
        send_ctrl(8'h40);
        send_payload(8'h77, "R12 write at 127");
        send_payload(8'h78, "R12 write wraps to 0");
        bus_stop();
        set_addr(126);
        open_read();
        fetch(1'b1, "R12 read 126");
        fetch(1'b1, "R12 read 127");
        fetch(1'b0, "R12 read wraps to 0");
        bus_stop();

        // R1: pin-selected address bit
        bus_start();
        send_addr(8'h76, 1'b0, "R1 mismatch not acked");
        bus_stop();
        check("R1 released after miss", int'(sda_oe_o), 0);
        addr_pin = 1'b1;
        tick(4);
        bus_start();
        send_addr(8'h76, 1'b1, "R1 pin-high address acked");
        send_ctrl(8'h00);
        send_payload(8'h20, "R6 ignored ack");
        bus_stop();
        bus_start();
        send_addr(WR_ADDR, 1'b0, "R1 pin-low address now missed");
        bus_stop();
        addr_pin = 1'b0;
        tick(4);

        // R11: stop in the middle of a data byte leaves RAM and counter alone
        keep_ac = mdl_ac;
        bus_start();
        send_addr(WR_ADDR, 1'b1, "R1 write address ack");
        send_ctrl(8'h40);
        partial_bits(8'hEE, 4);
        bus_stop();
        check("R11 released after abort", int'(sda_oe_o), 0);
        bus_start();
        send_addr(WR_ADDR, 1'b1, "R1 write address ack");
        send_ctrl(8'h40);
        send_payload(8'h5A, "R11 counter kept after abort");
        bus_stop();
        set_addr(keep_ac);
        open_read();
        fetch(1'b0, "R11 aborted byte not stored");
        bus_stop();

        tick(10);
        finish_run();
    end
endmodule